// File: doc/BRIEF.md
# Prioritised Interrupt Router

This block gathers a set of interrupt request lines and distributes them to several interrupt targets. Each request line passes through a gateway that captures it either while it is high (level mode) or on its low-to-high transition (edge mode). A captured request becomes a pending bit. For every target, a selector picks the best pending source. A source qualifies only if it is enabled for that target and its priority is strictly above that target's threshold. Among qualifying sources the highest priority wins, and the lower ID wins a tie.

Software reaches the block through a single-cycle strobe interface. The interface carries a register kind, a target index, a source index and a data word. Read data is combinational and valid in the same cycle as the read strobe. A read of a target's claim port returns the selected ID and hands that source to software. A later write of the same ID to any claim port releases the source. While a source is handed out, its gateway drops all new requests. Each target also has a software interrupt bit that drives a dedicated output.

Top module: `irq_hub`

## Requirements
- R1: After reset, every pending bit, priority, mode, enable, threshold and software bit is 0. Every `irq_o` and `swi_o` bit is 0 and every `irq_id_o` field is 0.
- R2: In level mode (mode kind 0 written with 0), a high request sets the source's pending bit at the next clock edge. The pending bit is read with kind 2, and bit 0 of the read data holds it. A request that is low when the source is released does not set pending again.
- R3: In edge mode (mode kind 0 written with 1), only a 0-to-1 transition of the request sets pending. A request still held high after release does not set pending again.
- R4: A source qualifies for a target only if it is pending, its enable bit for that target is 1 (kind 3, data bit 0), and its priority (kind 1) is strictly greater than the target's threshold (kind 4). A priority of 0 never qualifies. Priority reads back through kind 1.
- R5: Each target's `irq_id_o` is the qualifying source with the highest priority, and the lowest ID among equals. It is 0 when none qualifies. `irq_o` of that target is 1 exactly when its ID is non-zero.
- R6: A read with kind 5 returns the target's current `irq_id_o` in the same cycle. If that ID is non-zero, the source's pending bit clears at the clock edge and the source becomes claimed. A read that returns 0 changes nothing.
- R7: While a source is claimed, its gateway ignores requests. If a request edge arrives in the same cycle as the claim, the claim takes precedence and the edge is dropped.
- R8: Writing a claimed source's ID with kind 5 releases that source. In level mode, a request that is still high then sets pending on the following clock edge.
- R9: A kind 5 write of an ID that is not claimed, or of ID 0, has no effect.
- R10: Writing kind 6 sets that target's `swi_o` bit to data bit 0 at the clock edge.
- R11: Pending bits cannot be written: a kind 2 write has no effect. Source 0 has no request input and always reads as not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a read of kind 5 performs a claim) |
| reg_kind | input | 3 | Register kind: 0 mode, 1 priority, 2 pending, 3 enable, 4 threshold, 5 claim/release, 6 software interrupt |
| reg_tgt | input | TGT_W | Target index for kinds 3 to 6 |
| reg_src | input | ID_W | Source index for kinds 0 to 3 |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the addressed register, combinational |
| src_req | input | N_SRC-1 | Request lines of sources 1 to N_SRC-1 |
| irq_o | output | N_TGT | Interrupt line per target |
| irq_id_o | output | N_TGT x ID_W | Selected source ID per target |
| swi_o | output | N_TGT | Software interrupt line per target |

## Verification
The gateway sees a request transition at the same clock edge at which software claims that source. This happens in edge mode when the request rises in the cycle of a claim read. The bench holds the edge-mode request low after a first capture. It then raises the request in the same cycle as it asserts the claim read. It judges the outcome by releasing the source and reading the pending bit, which must stay 0. A second overlap tested is a release in the same cycle as a still-high level request. The pending bit must come back exactly one cycle later.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [2:0] {
    K_MODE  = 3'd0,
    K_PRIO  = 3'd1,
    K_PEND  = 3'd2,
    K_EN    = 3'd3,
    K_THR   = 3'd4,
    K_CLAIM = 3'd5,
    K_SWI   = 3'd6
  } reg_kind_e;

  // number of bits needed to hold value v (at least 1)
  function automatic int bits_for(int v);
    int r;
    int x;
    r = 0;
    x = v;
    while (x > 0) begin
      r = r + 1;
      x = x >> 1;
    end
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic edge_mode,
  input  logic claim,
  input  logic release_i,
  output logic pending,
  output logic busy
);

  logic req_q;
  logic pending_d;
  logic busy_d;
  logic capture;

  // capture condition depends on mode; busy masks everything
  always_comb begin
    if (edge_mode) begin
      capture = req & ~req_q;
    end else begin
      capture = req;
    end

    pending_d = pending;
    busy_d    = busy;
    if (claim) begin
      pending_d = 1'b0;
      busy_d    = 1'b1;
    end else begin
      if (capture && !busy) begin
        pending_d = 1'b1;
      end
      if (release_i) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      pending <= 1'b0;
      busy    <= 1'b0;
    end else begin
      req_q   <= req;
      pending <= pending_d;
      busy    <= busy_d;
    end
  end

endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 3
) (
  input  logic [N_SRC-1:0]             pending,
  input  logic [N_SRC-1:0]             enable,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]            thresh,
  output logic [ID_W-1:0]              best_id,
  output logic                         active
);

  logic [PRIO_W-1:0] best_prio;

  // ascending scan with strict compare: equal priority keeps the lower ID
  always_comb begin
    best_id   = '0;
    best_prio = '0;
    for (int s = 1; s < N_SRC; s++) begin
      if (pending[s] && enable[s] && (prio[s] > thresh) && (prio[s] > best_prio)) begin
        best_prio = prio[s];
        best_id   = ID_W'(s);
      end
    end
  end

  assign active = (best_id != '0);

endmodule

// File: rtl/irq_cfg.sv
module irq_cfg
  import irq_hub_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TGT  = 2,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 3,
  parameter int TGT_W  = 1,
  parameter int DATA_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [2:0]                   kind,
  input  logic [TGT_W-1:0]             tgt,
  input  logic [ID_W-1:0]              src,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [N_SRC-1:0]             pending,
  input  logic [N_TGT-1:0][ID_W-1:0]   sel_id,
  output logic [N_SRC-1:0]             mode,
  output logic [N_SRC-1:0][PRIO_W-1:0] prio,
  output logic [N_TGT-1:0][N_SRC-1:0]  enable,
  output logic [N_TGT-1:0][PRIO_W-1:0] thresh,
  output logic [N_TGT-1:0]             swi,
  output logic [DATA_W-1:0]            rdata
);

  reg_kind_e kind_e;
  logic      we_mode, we_prio, we_en, we_thr, we_swi;

  logic [N_SRC-1:0]             mode_d;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_d;
  logic [N_TGT-1:0][N_SRC-1:0]  enable_d;
  logic [N_TGT-1:0][PRIO_W-1:0] thresh_d;
  logic [N_TGT-1:0]             swi_d;

  assign kind_e  = reg_kind_e'(kind);
  assign we_mode = wr && (kind_e == K_MODE);
  assign we_prio = wr && (kind_e == K_PRIO);
  assign we_en   = wr && (kind_e == K_EN);
  assign we_thr  = wr && (kind_e == K_THR);
  assign we_swi  = wr && (kind_e == K_SWI);

  // next state: each field is loaded only under its own enable
  always_comb begin
    mode_d   = mode;
    prio_d   = prio;
    enable_d = enable;
    thresh_d = thresh;
    swi_d    = swi;
    if (we_mode) mode_d[src]        = wdata[0];
    if (we_prio) prio_d[src]        = wdata[PRIO_W-1:0];
    if (we_en)   enable_d[tgt][src] = wdata[0];
    if (we_thr)  thresh_d[tgt]      = wdata[PRIO_W-1:0];
    if (we_swi)  swi_d[tgt]         = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      prio   <= '0;
      enable <= '0;
      thresh <= '0;
      swi    <= '0;
    end else begin
      mode   <= mode_d;
      prio   <= prio_d;
      enable <= enable_d;
      thresh <= thresh_d;
      swi    <= swi_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (kind_e)
      K_MODE:  rdata[0]          = mode[src];
      K_PRIO:  rdata[PRIO_W-1:0] = prio[src];
      K_PEND:  rdata[0]          = pending[src];
      K_EN:    rdata[0]          = enable[tgt][src];
      K_THR:   rdata[PRIO_W-1:0] = thresh[tgt];
      K_CLAIM: rdata[ID_W-1:0]   = sel_id[tgt];
      K_SWI:   rdata[0]          = swi[tgt];
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int N_TGT    = 2,
  parameter int MAX_PRIO = 7,
  localparam int ID_W    = bits_for(N_SRC - 1),
  localparam int PRIO_W  = bits_for(MAX_PRIO),
  localparam int TGT_W   = (N_TGT > 1) ? bits_for(N_TGT - 1) : 1,
  localparam int DATA_W  = (PRIO_W > ID_W) ? PRIO_W : ID_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [2:0]                 reg_kind,
  input  logic [TGT_W-1:0]           reg_tgt,
  input  logic [ID_W-1:0]            reg_src,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [N_SRC-1:1]           src_req,
  output logic [N_TGT-1:0]           irq_o,
  output logic [N_TGT-1:0][ID_W-1:0] irq_id_o,
  output logic [N_TGT-1:0]           swi_o
);

  logic [N_SRC-1:0]             mode;
  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic [N_TGT-1:0][N_SRC-1:0]  enable;
  logic [N_TGT-1:0][PRIO_W-1:0] thresh;
  logic [N_SRC-1:0]             pending;
  logic [N_SRC-1:1]             busy_q;
  logic [N_SRC-1:1]             claim_vec;
  logic [N_SRC-1:1]             release_vec;
  logic                         claim_rd;
  logic                         release_wr;
  logic [ID_W-1:0]              claim_id;
  logic [ID_W-1:0]              release_id;

  irq_cfg #(
    .N_SRC (N_SRC),
    .N_TGT (N_TGT),
    .PRIO_W(PRIO_W),
    .ID_W  (ID_W),
    .TGT_W (TGT_W),
    .DATA_W(DATA_W)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .kind   (reg_kind),
    .tgt    (reg_tgt),
    .src    (reg_src),
    .wdata  (reg_wdata),
    .pending(pending),
    .sel_id (irq_id_o),
    .mode   (mode),
    .prio   (prio),
    .enable (enable),
    .thresh (thresh),
    .swi    (swi_o),
    .rdata  (reg_rdata)
  );

  // claim/release decode
  assign claim_rd   = reg_rd && (reg_kind_e'(reg_kind) == K_CLAIM);
  assign release_wr = reg_wr && (reg_kind_e'(reg_kind) == K_CLAIM);
  assign claim_id   = irq_id_o[reg_tgt];
  assign release_id = reg_wdata[ID_W-1:0];

  assign pending[0] = 1'b0;

  for (genvar s = 1; s < N_SRC; s++) begin : g_src
    assign claim_vec[s]   = claim_rd && (claim_id == ID_W'(s));
    assign release_vec[s] = release_wr && (release_id == ID_W'(s)) && busy_q[s];

    irq_gateway u_gw (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (src_req[s]),
      .edge_mode(mode[s]),
      .claim    (claim_vec[s]),
      .release_i(release_vec[s]),
      .pending  (pending[s]),
      .busy     (busy_q[s])
    );
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    irq_select #(
      .N_SRC (N_SRC),
      .PRIO_W(PRIO_W),
      .ID_W  (ID_W)
    ) u_sel (
      .pending(pending),
      .enable (enable[t]),
      .prio   (prio),
      .thresh (thresh[t]),
      .best_id(irq_id_o[t]),
      .active (irq_o[t])
    );
  end

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int N_SRC  = 8,
  parameter int N_TGT  = 2,
  parameter int ID_W   = 3,
  parameter int TGT_W  = 1,
  parameter int DATA_W = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic                       reg_rd,
  input logic [2:0]                 reg_kind,
  input logic [TGT_W-1:0]           reg_tgt,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic [N_TGT-1:0]           irq_o,
  input logic [N_TGT-1:0][ID_W-1:0] irq_id_o,
  input logic [N_TGT-1:0]           swi_o,
  input logic [N_SRC-1:0]           pending,
  input logic [N_SRC-1:0]           busy
);

  logic            lc_v;
  logic [ID_W-1:0] lc_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_v  <= 1'b0;
      lc_id <= '0;
    end else begin
      lc_v  <= reg_rd && (reg_kind == 3'd5) && (irq_id_o[reg_tgt] != '0);
      lc_id <= irq_id_o[reg_tgt];
    end
  end

  // R6
  claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lc_v |-> (!pending[lc_id] && busy[lc_id]));

  // R10
  swi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_kind == 3'd6)) |=> (swi_o[$past(reg_tgt)] == $past(reg_wdata[0])));

  // R9
  bogus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rd && (reg_kind == 3'd5) && !busy[reg_wdata[ID_W-1:0]]) |=> $stable(busy));

  for (genvar s = 1; s < N_SRC; s++) begin : g_s
    // R7
    blocked_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending[s]) |-> !$past(busy[s]));
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_t
    // R5
    irq_id_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[t] == (irq_id_o[t] != '0));
  end

  // R11
  src0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pending[0] && !busy[0]);

endmodule

bind irq_hub irq_hub_chk #(
  .N_SRC (N_SRC),
  .N_TGT (N_TGT),
  .ID_W  (ID_W),
  .TGT_W (TGT_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_kind (reg_kind),
  .reg_tgt  (reg_tgt),
  .reg_wdata(reg_wdata),
  .irq_o    (irq_o),
  .irq_id_o (irq_id_o),
  .swi_o    (swi_o),
  .pending  (pending),
  .busy     ({busy_q, 1'b0})
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;

  localparam int NS = 8;
  localparam int NT = 2;
  localparam int IW = 3;
  localparam int DW = 3;
  localparam int KMODE = 0, KPRIO = 1, KPEND = 2, KEN = 3, KTHR = 4, KCLM = 5, KSWI = 6;

  logic                   clk;
  logic                   rst_n;
  logic                   reg_wr;
  logic                   reg_rd;
  logic [2:0]             reg_kind;
  logic [0:0]             reg_tgt;
  logic [IW-1:0]          reg_src;
  logic [DW-1:0]          reg_wdata;
  logic [DW-1:0]          reg_rdata;
  logic [NS-1:1]          src_req;
  logic [NT-1:0]          irq_o;
  logic [NT-1:0][IW-1:0]  irq_id_o;
  logic [NT-1:0]          swi_o;

  int total;
  int bad;
  bit done;

  irq_hub u_irq_hub (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_kind (reg_kind),
    .reg_tgt  (reg_tgt),
    .reg_src  (reg_src),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .src_req  (src_req),
    .irq_o    (irq_o),
    .irq_id_o (irq_id_o),
    .swi_o    (swi_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wreg(int k, int t, int s, int d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_kind  = k[2:0];
    reg_tgt   = t[0:0];
    reg_src   = s[IW-1:0];
    reg_wdata = d[DW-1:0];
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rreg(int k, int t, int s, output int v);
    @(negedge clk);
    reg_rd   = 1'b1;
    reg_kind = k[2:0];
    reg_tgt  = t[0:0];
    reg_src  = s[IW-1:0];
    #1 v = int'(reg_rdata);
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic set_req(int s, bit v);
    @(negedge clk);
    src_req[s] = v;
  endtask

  task automatic drain(int t);
    int v;
    for (int i = 0; i < NS; i++) begin
      rreg(KCLM, t, 0, v);
      if (v == 0) break;
      wreg(KCLM, t, 0, v);
    end
  endtask

  task automatic t_reset;
    int v;
    chk("R1 irq_o", int'(irq_o), 0);
    chk("R1 swi_o", int'(swi_o), 0);
    chk("R1 irq_id t1", int'(irq_id_o[1]), 0);
    rreg(KPRIO, 0, 1, v);   chk("R1 prio", v, 0);
    rreg(KTHR, 1, 0, v);    chk("R1 thresh", v, 0);
    rreg(KPEND, 0, 3, v);   chk("R1 pending", v, 0);
    rreg(KCLM, 0, 0, v);    chk("R6 empty claim", v, 0);
  endtask

  task automatic t_level;
    int v;
    wreg(KMODE, 0, 2, 0);
    wreg(KPRIO, 0, 2, 3);
    wreg(KEN, 0, 2, 1);
    set_req(2, 1'b1);
    rreg(KPEND, 0, 2, v);   chk("R2 level pend", v, 1);
    chk("R5 irq on", int'(irq_o[0]), 1);
    rreg(KCLM, 0, 0, v);    chk("R6 claim id", v, 2);
    rreg(KPEND, 0, 2, v);   chk("R6 pend cleared", v, 0);
    idle(3);
    rreg(KPEND, 0, 2, v);   chk("R7 held level ignored", v, 0);
    wreg(KCLM, 0, 0, 2);
    idle(1);
    rreg(KPEND, 0, 2, v);   chk("R8 level re-pend", v, 1);
    set_req(2, 1'b0);
    rreg(KCLM, 0, 0, v);    chk("R6 claim again", v, 2);
    wreg(KCLM, 0, 0, 2);
    idle(2);
    rreg(KPEND, 0, 2, v);   chk("R2 low no re-pend", v, 0);
  endtask

  task automatic t_edge;
    int v;
    wreg(KMODE, 0, 5, 1);
    wreg(KPRIO, 0, 5, 2);
    wreg(KEN, 0, 5, 1);
    set_req(5, 1'b1);
    rreg(KPEND, 0, 5, v);   chk("R3 edge pend", v, 1);
    rreg(KCLM, 0, 0, v);    chk("R3 claim", v, 5);
    wreg(KCLM, 0, 0, 5);
    idle(2);
    rreg(KPEND, 0, 5, v);   chk("R3 held high no re-pend", v, 0);
    set_req(5, 1'b0);
    set_req(5, 1'b1);
    rreg(KPEND, 0, 5, v);   chk("R3 new edge", v, 1);
    rreg(KCLM, 0, 0, v);
    wreg(KCLM, 0, 0, v);
    set_req(5, 1'b0);
  endtask

  task automatic t_prio;
    int v;
    wreg(KPRIO, 0, 3, 4);
    wreg(KPRIO, 0, 4, 4);
    wreg(KPRIO, 0, 6, 6);
    wreg(KEN, 0, 3, 1);
    wreg(KEN, 0, 4, 1);
    wreg(KEN, 0, 6, 1);
    set_req(3, 1'b1);
    set_req(4, 1'b1);
    idle(1);
    chk("R5 tie lowest id", int'(irq_id_o[0]), 3);
    set_req(6, 1'b1);
    idle(1);
    chk("R5 highest prio", int'(irq_id_o[0]), 6);
    wreg(KTHR, 0, 0, 6);
    chk("R4 equal to thresh", int'(irq_o[0]), 0);
    chk("R4 id zero", int'(irq_id_o[0]), 0);
    wreg(KTHR, 0, 0, 3);
    chk("R4 above thresh", int'(irq_id_o[0]), 6);
    wreg(KEN, 0, 6, 0);
    chk("R4 disabled skip", int'(irq_id_o[0]), 3);
    wreg(KTHR, 0, 0, 0);
    wreg(KPRIO, 0, 3, 0);
    chk("R4 prio zero", int'(irq_id_o[0]), 4);
    chk("R4 other target", int'(irq_o[1]), 0);
    rreg(KPRIO, 0, 4, v);   chk("R4 prio readback", v, 4);
    wreg(KEN, 1, 4, 1);
    chk("R5 per target", int'(irq_id_o[1]), 4);
    set_req(3, 1'b0);
    set_req(4, 1'b0);
    set_req(6, 1'b0);
    wreg(KEN, 1, 4, 0);
    wreg(KPRIO, 0, 3, 4);
    wreg(KEN, 0, 6, 1);
    drain(0);
    chk("R5 drained", int'(irq_o[0]), 0);
  endtask

  task automatic t_race;
    int v;
    wreg(KMODE, 0, 7, 1);
    wreg(KPRIO, 0, 7, 5);
    wreg(KEN, 0, 7, 1);
    set_req(7, 1'b1);
    set_req(7, 1'b0);
    idle(1);
    // new edge arrives in the same cycle as the claim read
    @(negedge clk);
    src_req[7] = 1'b1;
    reg_rd     = 1'b1;
    reg_kind   = 3'(KCLM);
    reg_tgt    = 1'b0;
    #1 v = int'(reg_rdata);
    @(posedge clk);
    #1 reg_rd = 1'b0;
    chk("R7 race claim id", v, 7);
    wreg(KCLM, 0, 0, 7);
    idle(2);
    rreg(KPEND, 0, 7, v);   chk("R7 race edge dropped", v, 0);
    set_req(7, 1'b0);
  endtask

  task automatic t_bogus;
    int v;
    wreg(KPRIO, 0, 1, 1);
    wreg(KEN, 0, 1, 1);
    set_req(1, 1'b1);
    rreg(KCLM, 0, 0, v);    chk("R6 claim src1", v, 1);
    wreg(KCLM, 0, 0, 4);
    wreg(KCLM, 1, 0, 0);
    idle(2);
    rreg(KPEND, 0, 1, v);   chk("R9 stray release ignored", v, 0);
    chk("R9 no irq", int'(irq_o[0]), 0);
    wreg(KCLM, 1, 0, 1);
    idle(1);
    rreg(KPEND, 0, 1, v);   chk("R8 release then re-pend", v, 1);
    set_req(1, 1'b0);
    drain(0);
  endtask

  task automatic t_swi;
    wreg(KSWI, 1, 0, 1);    chk("R10 swi t1 set", int'(swi_o), 2);
    wreg(KSWI, 0, 0, 1);    chk("R10 swi both", int'(swi_o), 3);
    wreg(KSWI, 1, 0, 0);    chk("R10 swi t1 clear", int'(swi_o), 1);
    wreg(KSWI, 0, 0, 0);    chk("R10 swi t0 clear", int'(swi_o), 0);
  endtask

  task automatic t_pend_ro;
    int v;
    wreg(KEN, 0, 3, 1);
    wreg(KPEND, 0, 3, 1);
    rreg(KPEND, 0, 3, v);   chk("R11 pend write ignored", v, 0);
    chk("R11 no irq", int'(irq_o[0]), 0);
    rreg(KPEND, 0, 0, v);   chk("R11 src0 never pending", v, 0);
  endtask

  initial begin
    total     = 0;
    bad       = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_rd    = 1'b0;
    reg_kind  = '0;
    reg_tgt   = '0;
    reg_src   = '0;
    reg_wdata = '0;
    src_req   = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_level;
    t_edge;
    t_prio;
    t_race;
    t_bogus;
    t_swi;
    t_pend_ro;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule